// File: doc/BRIEF.md
# Four-Step Single-Tone Self-Test Sequencer

This block runs the control side of an on-chip single-tone test for an oversampled converter. A start command launches a fixed sequence of up to four measurement steps. Before each step the block restarts the stimulus and reference bitstream generators at the amplitudes that step needs. It then waits a fixed settling time, arms the output analyzer and waits for the analyzer's done strobe. For every step it also chooses what reaches the decimator: the converter's output bit, the reference bit, or the difference between the converter bit and the reference bit delayed by two clocks.

A test needs only two setup values: a frequency word, which all steps share, and a base amplitude. The amplitude found in the second step is reused as the reference amplitude in the last step. An optional third step measures the gain the decimation path gives the reference, and that result sets the stimulus amplitude of the last step. When the optional step is disabled, that amplitude comes from a value supplied at start. The block latches all setup inputs at start, so the inputs may change freely during a run.

Top module: `selftest_seq_top`

## Requirements
- R1: After reset, busy_o=0, done_o=0, step_o=0, gen_restart_o=0, ana_arm_o=0, both amplitude outputs are 0 and dec_in_o=0, whatever the bit inputs are.
- R2: A start_i sampled while idle gives, in the following cycle, busy_o=1, step_o=0, a one-cycle gen_restart_o pulse, and freq_o equal to the freq_i sampled with the start.
- R3: In every step, ana_arm_o is a one-cycle pulse exactly SETTLE_CYC cycles after the cycle that shows gen_restart_o. The analyzer mode (ana_mode_o: 0 offset, 1 amplitude, 2 power) is valid while the pulse is high.
- R4: step_o=0 and step_o=1 (the first two steps) drive stim_amp_o with the latched base amplitude and ref_amp_o=0. Their modes are offset and amplitude, offset_hold_o is 0 and then 1, and the decimator gets the converter bit as +1 (bit 1) or -1 (bit 0).
- R5: When the optional step is enabled, step_o=2 drives ref_amp_o with the base amplitude and stim_amp_o=0. Its mode is amplitude with offset_hold_o=1, and the decimator gets the undelayed reference bit as +1 or -1.
- R6: step_o=3 drives ref_amp_o with the analyzer result latched at the end of step_o=1. stim_amp_o is the result latched at the end of step_o=2 when the optional step is enabled; otherwise it is the amp_ext_i sampled at start, and step_o goes straight from 1 to 3. Its mode is power with offset_hold_o=1, and step_o never decreases during a run.
- R7: In step_o=3, dec_in_o (3-bit two's complement) equals (+1/-1 of conv_bit_i) minus (+1/-1 of the ref_bit_i from two cycles earlier), so it takes only the values +2, 0 and -2.
- R8: ana_done_i has no effect outside the wait for a result that follows an arm pulse. start_i during a run changes neither step_o, busy_o nor freq_o.
- R9: The done strobe of step_o=3 makes the next cycle idle: busy_o=0, done_o=1, step_o=0, both amplitudes 0 and dec_in_o=0. done_o holds until the next start, which clears it.
- R10: Changes to freq_i, amp_init_i, amp_ext_i and opt_en_i after start do not affect the outputs of the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a test (sampled only while idle) |
| opt_en_i | input | 1 | Include the optional gain-measuring step |
| freq_i | input | FREQ_W | Oscillator frequency word |
| amp_init_i | input | AMP_W | Base amplitude (target amplitude times pi/4) |
| amp_ext_i | input | AMP_W | Last-step stimulus amplitude when the optional step is skipped |
| conv_bit_i | input | 1 | Converter output bit |
| ref_bit_i | input | 1 | Reference generator bit |
| ana_done_i | input | 1 | Analyzer result-ready strobe |
| ana_result_i | input | AMP_W | Analyzer amplitude result |
| step_o | output | 2 | Current step index, 0 to 3 |
| busy_o | output | 1 | Test running |
| done_o | output | 1 | Test finished |
| gen_restart_o | output | 1 | Restart both generators |
| freq_o | output | FREQ_W | Latched frequency word |
| stim_amp_o | output | AMP_W | Stimulus generator amplitude |
| ref_amp_o | output | AMP_W | Reference generator amplitude |
| ana_arm_o | output | 1 | Start analyzer accumulation |
| ana_mode_o | output | 2 | Analyzer estimator select |
| offset_hold_o | output | 1 | Freeze the stored offset and subtract it |
| dec_in_o | output | 3 | Signed decimator input sample |

## Verification
A wrong step index or phase appears at once at the amplitude outputs, ana_mode_o and dec_in_o in the same cycle. A wrong settle counter moves the arm pulse away from its expected cycle. A lost or mis-latched analyzer result becomes visible only when step 3 begins, as a wrong ref_amp_o or stim_amp_o. A delay line of the wrong length shows within two cycles of step 3 as nonzero differences where the bench expects zero. A skip that does not happen shows as step_o=2 appearing while the optional step is disabled.

// File: rtl/selftest_seq_pkg.sv
package selftest_seq_pkg;

    localparam int DEC_W = 3;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_ARM    = 2'd2,
        PH_WAIT   = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        EST_OFFSET = 2'd0,
        EST_AMPL   = 2'd1,
        EST_POWER  = 2'd2,
        EST_NONE   = 2'd3
    } est_t;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_CONV = 2'd1,
        RT_REF  = 2'd2,
        RT_DIFF = 2'd3
    } route_t;

    typedef struct packed {
        route_t route;
        est_t   est;
        logic   os_hold;
    } step_cfg_t;

    function automatic step_cfg_t step_cfg(input logic [1:0] s);
        step_cfg_t c;
        case (s)
            2'd0: begin c.route = RT_CONV; c.est = EST_OFFSET; c.os_hold = 1'b0; end
            2'd1: begin c.route = RT_CONV; c.est = EST_AMPL;   c.os_hold = 1'b1; end
            2'd2: begin c.route = RT_REF;  c.est = EST_AMPL;   c.os_hold = 1'b1; end
            default: begin c.route = RT_DIFF; c.est = EST_POWER; c.os_hold = 1'b1; end
        endcase
        return c;
    endfunction

    function automatic logic signed [DEC_W-1:0] bit_pm1(input logic b);
        return b ? DEC_W'(1) : -DEC_W'(1);
    endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import selftest_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 512,
    parameter int FREQ_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              opt_en_i,
    input  logic [FREQ_W-1:0] freq_i,
    input  logic              ana_done_i,
    output logic [1:0]        step_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              opt_o,
    output logic              gen_restart_o,
    output logic              arm_o,
    output logic              latch_o,
    output logic              cfg_load_o,
    output logic [FREQ_W-1:0] freq_o,
    output route_t            route_o,
    output est_t              est_o,
    output logic              hold_o
);
    localparam int CNT_W = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [1:0] LAST_STEP = 2'd3;

    phase_t           phase_q;
    logic [1:0]       step_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             opt_q;
    logic [FREQ_W-1:0] freq_q;
    logic [1:0]       step_nx;
    step_cfg_t        cfg;

    always_comb begin
        case (step_q)
            2'd0:    step_nx = 2'd1;
            2'd1:    step_nx = opt_q ? 2'd2 : 2'd3;
            default: step_nx = 2'd3;
        endcase
    end

    assign cfg_load_o = (phase_q == PH_IDLE) && start_i;
    assign latch_o    = (phase_q == PH_WAIT) && ana_done_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= 2'd0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            opt_q   <= 1'b0;
            freq_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_SETTLE;
                        step_q  <= 2'd0;
                        cnt_q   <= '0;
                        done_q  <= 1'b0;
                        opt_q   <= opt_en_i;
                        freq_q  <= freq_i;
                    end
                end
                PH_SETTLE: begin
                    if (cnt_q == CNT_LAST) phase_q <= PH_ARM;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end
                PH_ARM: phase_q <= PH_WAIT;
                default: begin
                    if (ana_done_i) begin
                        cnt_q <= '0;
                        if (step_q == LAST_STEP) begin
                            phase_q <= PH_IDLE;
                            step_q  <= 2'd0;
                            done_q  <= 1'b1;
                        end else begin
                            phase_q <= PH_SETTLE;
                            step_q  <= step_nx;
                        end
                    end
                end
            endcase
        end
    end

    assign cfg           = step_cfg(step_q);
    assign busy_o        = (phase_q != PH_IDLE);
    assign step_o        = step_q;
    assign done_o        = done_q;
    assign opt_o         = opt_q;
    assign freq_o        = freq_q;
    assign gen_restart_o = (phase_q == PH_SETTLE) && (cnt_q == '0);
    assign arm_o         = (phase_q == PH_ARM);
    assign route_o       = busy_o ? cfg.route : RT_NONE;
    assign est_o         = busy_o ? cfg.est : EST_NONE;
    assign hold_o        = busy_o && cfg.os_hold;

    // R3
    arm_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
        arm_o |-> ($past(phase_q) == PH_SETTLE));

    // R2
    restart_single_chk: assert property (@(posedge clk) disable iff (rst)
        gen_restart_o |=> !gen_restart_o);

    // R8
    start_busy_ign_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !latch_o) |=> (busy_o && $stable(freq_o)));

    // R6
    step_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> (step_q >= $past(step_q)));

endmodule

// File: rtl/amp_route.sv
module amp_route #(
    parameter int AMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load_i,
    input  logic [AMP_W-1:0] amp_init_i,
    input  logic [AMP_W-1:0] amp_ext_i,
    input  logic             latch_i,
    input  logic [AMP_W-1:0] result_i,
    input  logic [1:0]       step_i,
    input  logic             busy_i,
    input  logic             opt_i,
    output logic [AMP_W-1:0] stim_amp_o,
    output logic [AMP_W-1:0] ref_amp_o
);
    logic [AMP_W-1:0] init_q, ext_q, gain_q, cal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q <= '0;
            ext_q  <= '0;
            gain_q <= '0;
            cal_q  <= '0;
        end else if (cfg_load_i) begin
            init_q <= amp_init_i;
            ext_q  <= amp_ext_i;
            gain_q <= '0;
            cal_q  <= '0;
        end else if (latch_i) begin
            if (step_i == 2'd1) gain_q <= result_i;
            if (step_i == 2'd2) cal_q  <= result_i;
        end
    end

    always_comb begin
        stim_amp_o = '0;
        ref_amp_o  = '0;
        if (busy_i) begin
            case (step_i)
                2'd0, 2'd1: stim_amp_o = init_q;
                2'd2:       ref_amp_o  = init_q;
                default: begin
                    ref_amp_o  = gain_q;
                    stim_amp_o = opt_i ? cal_q : ext_q;
                end
            endcase
        end
    end

    // R5
    opt_step_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && step_i == 2'd2) |-> (stim_amp_o == '0 && ref_amp_o == init_q));

endmodule

// File: rtl/residue_path.sv
module residue_path
    import selftest_seq_pkg::*;
#(
    parameter int REF_DLY = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  route_t                  route_i,
    input  logic                    conv_bit_i,
    input  logic                    ref_bit_i,
    output logic signed [DEC_W-1:0] dec_o
);
    logic dly_q [REF_DLY];

    for (genvar i = 0; i < REF_DLY; i++) begin : g_dly
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) dly_q[i] <= 1'b0;
                else     dly_q[i] <= ref_bit_i;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) dly_q[i] <= 1'b0;
                else     dly_q[i] <= dly_q[i-1];
            end
        end
    end

    always_comb begin
        case (route_i)
            RT_CONV: dec_o = bit_pm1(conv_bit_i);
            RT_REF:  dec_o = bit_pm1(ref_bit_i);
            RT_DIFF: dec_o = bit_pm1(conv_bit_i) - bit_pm1(dly_q[REF_DLY-1]);
            default: dec_o = '0;
        endcase
    end

    // R7
    diff_even_chk: assert property (@(posedge clk) disable iff (rst)
        (route_i == RT_DIFF) |-> (dec_o[0] == 1'b0));

    if (REF_DLY == 2) begin : g_dly_chk
        // R7
        diff_align_chk: assert property (@(posedge clk) disable iff (rst)
            (route_i == RT_DIFF && conv_bit_i == $past(ref_bit_i, 2)) |-> (dec_o == '0));
    end

endmodule

// File: rtl/selftest_seq_top.sv
module selftest_seq_top
    import selftest_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 512,
    parameter int FREQ_W     = 16,
    parameter int AMP_W      = 16,
    parameter int REF_DLY    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              opt_en_i,
    input  logic [FREQ_W-1:0] freq_i,
    input  logic [AMP_W-1:0]  amp_init_i,
    input  logic [AMP_W-1:0]  amp_ext_i,
    input  logic              conv_bit_i,
    input  logic              ref_bit_i,
    input  logic              ana_done_i,
    input  logic [AMP_W-1:0]  ana_result_i,
    output logic [1:0]        step_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              gen_restart_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic [AMP_W-1:0]  stim_amp_o,
    output logic [AMP_W-1:0]  ref_amp_o,
    output logic              ana_arm_o,
    output logic [1:0]        ana_mode_o,
    output logic              offset_hold_o,
    output logic [DEC_W-1:0]  dec_in_o
);
    logic   opt_w, latch_w, load_w;
    route_t route_w;
    est_t   est_w;
    logic signed [DEC_W-1:0] dec_w;

    seq_ctrl #(.SETTLE_CYC(SETTLE_CYC), .FREQ_W(FREQ_W)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .opt_en_i(opt_en_i),
        .freq_i(freq_i), .ana_done_i(ana_done_i), .step_o(step_o),
        .busy_o(busy_o), .done_o(done_o), .opt_o(opt_w),
        .gen_restart_o(gen_restart_o), .arm_o(ana_arm_o), .latch_o(latch_w),
        .cfg_load_o(load_w), .freq_o(freq_o), .route_o(route_w),
        .est_o(est_w), .hold_o(offset_hold_o)
    );

    amp_route #(.AMP_W(AMP_W)) u_amp (
        .clk(clk), .rst(rst), .cfg_load_i(load_w), .amp_init_i(amp_init_i),
        .amp_ext_i(amp_ext_i), .latch_i(latch_w), .result_i(ana_result_i),
        .step_i(step_o), .busy_i(busy_o), .opt_i(opt_w),
        .stim_amp_o(stim_amp_o), .ref_amp_o(ref_amp_o)
    );

    residue_path #(.REF_DLY(REF_DLY)) u_res (
        .clk(clk), .rst(rst), .route_i(route_w), .conv_bit_i(conv_bit_i),
        .ref_bit_i(ref_bit_i), .dec_o(dec_w)
    );

    assign ana_mode_o = est_w;
    assign dec_in_o   = dec_w;

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (stim_amp_o == '0 && ref_amp_o == '0 && dec_in_o == '0));

endmodule

// File: tb/sim_selftest_seq_top.sv
module sim_selftest_seq_top;
    localparam int SETTLE = 512;
    localparam int FW = 16;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, opt_en_i = 1'b0, conv_bit_i = 1'b0, ref_bit_i = 1'b0, ana_done_i = 1'b0;
    logic [FW-1:0] freq_i = '0;
    logic [AW-1:0] amp_init_i = '0, amp_ext_i = '0, ana_result_i = '0;
    logic [1:0] step_o, ana_mode_o;
    logic busy_o, done_o, gen_restart_o, ana_arm_o, offset_hold_o;
    logic [FW-1:0] freq_o;
    logic [AW-1:0] stim_amp_o, ref_amp_o;
    logic [2:0] dec_in_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic h1 = 1'b0, h2 = 1'b0;

    always #4 clk = ~clk;

    selftest_seq_top #(.SETTLE_CYC(SETTLE), .FREQ_W(FW), .AMP_W(AW)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .opt_en_i(opt_en_i),
        .freq_i(freq_i), .amp_init_i(amp_init_i), .amp_ext_i(amp_ext_i),
        .conv_bit_i(conv_bit_i), .ref_bit_i(ref_bit_i), .ana_done_i(ana_done_i),
        .ana_result_i(ana_result_i), .step_o(step_o), .busy_o(busy_o),
        .done_o(done_o), .gen_restart_o(gen_restart_o), .freq_o(freq_o),
        .stim_amp_o(stim_amp_o), .ref_amp_o(ref_amp_o), .ana_arm_o(ana_arm_o),
        .ana_mode_o(ana_mode_o), .offset_hold_o(offset_hold_o), .dec_in_o(dec_in_o)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock: drive fresh random bits after the falling edge, then settle
    task automatic tick();
        @(negedge clk);
        h2 = h1;
        h1 = ref_bit_i;
        conv_bit_i = 1'($urandom % 2);
        ref_bit_i  = 1'($urandom % 2);
        #1;
    endtask

    function automatic int exp_dec(input int route);
        case (route)
            1: return conv_bit_i ? 1 : -1;
            2: return ref_bit_i ? 1 : -1;
            3: return 2 * (int'(conv_bit_i) - int'(h2));
            default: return 0;
        endcase
    endfunction

    task automatic do_step(input int sidx, input int stim_e, input int ref_e, input int mode_e,
                           input int hold_e, input int route, input int result,
                           input bit inj_done, input bit inj_start, input int freq_e,
                           input string req);
        int n;
        string rr;
        chk("R2", "gen_restart at step entry", gen_restart_o, 1);
        chk("R6", "step index", step_o, sidx);
        n = 0;
        if (inj_done) begin
            ana_done_i = 1'b1;
            tick();
            ana_done_i = 1'b0;
            n = 1;
            chk("R8", "done in settle ignored, step", step_o, sidx);
        end
        while (!ana_arm_o && n < SETTLE + 50) begin
            tick();
            n++;
        end
        chk("R3", "settle length", n, SETTLE);
        chk(req, "stim amplitude", stim_amp_o, stim_e);
        chk(req, "ref amplitude", ref_amp_o, ref_e);
        chk(req, "analyzer mode", ana_mode_o, mode_e);
        chk(req, "offset hold", offset_hold_o, hold_e);
        tick();
        chk("R3", "arm is one cycle", ana_arm_o, 0);
        rr = (route == 3) ? "R7" : req;
        for (int k = 0; k < 12; k++) begin
            tick();
            chk(rr, "decimator input", $signed(dec_in_o), exp_dec(route));
        end
        if (inj_start) begin
            start_i = 1'b1;
            freq_i = FW'($urandom);
            tick();
            start_i = 1'b0;
            chk("R8", "start while busy, step", step_o, sidx);
            chk("R8", "start while busy, busy", busy_o, 1);
            chk("R8", "start while busy, freq", freq_o, freq_e);
        end
        ana_result_i = AW'(result);
        ana_done_i = 1'b1;
        tick();
        ana_done_i = 1'b0;
    endtask

    task automatic run_test(input bit opt);
        int fq, ini, ext, y2, y3;
        fq  = int'($urandom % 65536);
        ini = int'($urandom % 65536);
        ext = int'($urandom % 65536);
        y2  = int'($urandom % 65536);
        y3  = int'($urandom % 65536);
        start_i = 1'b1; opt_en_i = opt; freq_i = FW'(fq);
        amp_init_i = AW'(ini); amp_ext_i = AW'(ext);
        tick();
        start_i = 1'b0;
        chk("R2", "busy after start", busy_o, 1);
        chk("R9", "done cleared by start", done_o, 0);
        chk("R2", "freq latched", freq_o, fq);
        // R10: disturb the setup inputs for the rest of the run
        freq_i = FW'($urandom); amp_init_i = AW'($urandom);
        amp_ext_i = AW'($urandom); opt_en_i = ~opt;
        do_step(0, ini, 0, 0, 0, 1, int'($urandom % 65536), 1, 0, fq, "R4");
        do_step(1, ini, 0, 1, 1, 1, y2, 0, 1, fq, "R4");
        if (opt) do_step(2, 0, ini, 1, 1, 2, y3, 0, 0, fq, "R5");
        do_step(3, opt ? y3 : ext, y2, 2, 1, 3, int'($urandom % 65536), 0, 0, fq, "R6");
        chk("R9", "busy after finish", busy_o, 0);
        chk("R9", "done after finish", done_o, 1);
        chk("R9", "step after finish", step_o, 0);
        chk("R9", "stim after finish", stim_amp_o, 0);
        chk("R9", "ref after finish", ref_amp_o, 0);
        chk("R9", "dec after finish", dec_in_o, 0);
        chk("R10", "freq held through run", freq_o, fq);
        for (int k = 0; k < 3; k++) tick();
        chk("R9", "done held", done_o, 1);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int k = 0; k < 5; k++) tick();
        rst = 1'b0;
        tick();
        chk("R1", "busy", busy_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "step", step_o, 0);
        chk("R1", "restart", gen_restart_o, 0);
        chk("R1", "arm", ana_arm_o, 0);
        chk("R1", "stim", stim_amp_o, 0);
        chk("R1", "ref", ref_amp_o, 0);
        chk("R1", "dec", dec_in_o, 0);
        ana_done_i = 1'b1;
        tick();
        ana_done_i = 1'b0;
        chk("R8", "done while idle ignored", busy_o, 0);
        run_test(1'b1);
        run_test(1'b0);
        for (int t = 0; t < 4; t++) run_test(1'($urandom % 2));
        report();
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, actual 1 expected 0");
        report();
    end
endmodule